// File: doc/BRIEF.md
# Multi-Format TDM Audio Serial Port

This block moves audio sample words between a set of parallel channel ports and a serial link made of a bit clock, a frame sync, a data-in line and a data-out line. It runs as a slave in the bit-clock domain: the frame sync and the data-in line are sampled on the rising edge of `clk`. The data-out bit for each bit period is set up during that period, so the peer can sample it on the same rising edge. One position counter, restarted by the frame-sync edge, serves every frame format. Per-channel comparators against that counter decide which channel owns the current bit period.

The frame format, the PCM sub-variant, the word length, the slot length, the slot start offset and the number of channels (two, or four in TDM) come in on static configuration pins. The block captures the transmit words on the frame-start edge. It returns all received words at once, together with a one-cycle strobe, after the last active channel has been fully captured. The data-out line has a drive-enable control and a separate high-impedance control, so several ports can share one line.

Top module: `tdm_serial_port`

## Requirements
- R1: After reset, `rx_valid` is 0, `rx_data` is all zero and `sdo` is 0 while no frame has started.
- R2: The format code is `cfg_fmt`: 00 selects right-justified, 01 left-justified, 10 I2S and 11 PCM. A frame begins in the bit period in which `fs` is first seen high after being low, or first seen low after being high in I2S. That period is frame position 0.
- R3: Left-justified: the MSB of channel c is in position O + c*S, where O is `cfg_offset` and S is `cfg_slot_len`.
- R4: I2S: every channel starts one position later than in left-justified mode, and channel 0 is the half where `fs` is low.
- R5: Right-justified: the LSB of channel c is in position O + (c+1)*S - 1, the last bit of its slot.
- R6: PCM: with `cfg_pcm_dly`=0 the channel 0 MSB is in position O (the frame-sync edge). With `cfg_pcm_dly`=1 it is one position later. Each next channel's MSB directly follows the previous channel's LSB.
- R7: `cfg_offset` shifts all active channels together by the same number of positions, in every format.
- R8: With `cfg_tdm`=1 channels 0 to 3 are active. With `cfg_tdm`=0 only channels 0 and 1 are active, and positions of channels 2 and 3 carry 0 on `sdo`.
- R9: `cfg_wlen` sets the word length W: 0 gives 16, 1 gives 20, 2 gives 24 and 3 gives 32 bits. The word is sent MSB first, and its W low bits are taken from the channel's 32-bit field. Every position outside a word window drives 0. Received words are right-aligned, with zeros above bit W-1.
- R10: `rx_valid` is high for exactly one cycle, in the cycle after the last bit of the last active channel is sampled. `rx_data` changes only in that cycle and holds its value otherwise.
- R11: `sdo_oe` is 1 only when `cfg_out_en`=1 and `cfg_tri`=0.
- R12: The transmit words are those present on `tx_data` in frame position 0. Later changes during the frame do not alter `sdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 2 | Frame format code |
| cfg_pcm_dly | input | 1 | PCM sub-variant: 1 delays the first MSB by one bit |
| cfg_tdm | input | 1 | 1 enables four channels, 0 uses two |
| cfg_wlen | input | 2 | Word length code |
| cfg_slot_len | input | SLOT_W | Bit periods per channel slot (not used in PCM) |
| cfg_offset | input | OFS_W | Slot start offset in bit periods |
| cfg_out_en | input | 1 | Data-out drive enable |
| cfg_tri | input | 1 | Forces data-out to high impedance |
| fs | input | 1 | Frame sync |
| sdi | input | 1 | Serial data in |
| tx_data | input | NCH*WMAX | Transmit words, channel 0 in the low field |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data-out pad |
| rx_data | output | NCH*WMAX | Received words, channel 0 in the low field |
| rx_valid | output | 1 | One-cycle strobe marking new received words |

## Verification
The bench uses the default parameters: four channels, 32-bit fields and a 10-bit offset. It sweeps every combination of the five frame variants, the four word lengths, two and four channels, offsets of 0 and 5, and slot lengths of 32 and 36. This covers each slot boundary, the packed PCM layout, a word that fills its slot exactly, and a right-justified pad in front of a short word. Every bit period of every frame is compared against positions computed arithmetically. Data outside the windows is driven to 1 on `sdi` to show it is ignored. The transmit words are swapped one bit after frame start to show they were captured at the frame-start edge.

// File: rtl/tdm_serial_port.sv
module tdm_serial_port #(
  parameter int NCH    = 4,
  parameter int WMAX   = 32,
  parameter int OFS_W  = 10,
  parameter int SLOT_W = 7,
  parameter int CNT_W  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_fmt,
  input  logic                 cfg_pcm_dly,
  input  logic                 cfg_tdm,
  input  logic [1:0]           cfg_wlen,
  input  logic [SLOT_W-1:0]    cfg_slot_len,
  input  logic [OFS_W-1:0]     cfg_offset,
  input  logic                 cfg_out_en,
  input  logic                 cfg_tri,
  input  logic                 fs,
  input  logic                 sdi,
  input  logic [NCH*WMAX-1:0]  tx_data,
  output logic                 sdo,
  output logic                 sdo_oe,
  output logic [NCH*WMAX-1:0]  rx_data,
  output logic                 rx_valid
);
  localparam int IW = $clog2(WMAX);
  localparam logic [CNT_W-1:0] PMAX = '1;

  logic             fs_q;
  logic [CNT_W-1:0] cnt_q, pos, wl, stride, base;
  logic [NCH-1:0]   win_v, tx_bit, last_v;
  logic [NCH*WMAX-1:0] rx_nxt;
  logic             start, is_i2s, is_pcm, is_rj, done;

  assign is_i2s = (cfg_fmt == 2'b10);
  assign is_pcm = (cfg_fmt == 2'b11);
  assign is_rj  = (cfg_fmt == 2'b00);
  assign start  = is_i2s ? (fs_q & ~fs) : (~fs_q & fs);
  assign pos    = start ? '0 : (cnt_q == PMAX ? PMAX : cnt_q + 1'b1);

  always_comb begin
    case (cfg_wlen)
      2'd0:    wl = CNT_W'(16);
      2'd1:    wl = CNT_W'(20);
      2'd2:    wl = CNT_W'(24);
      default: wl = CNT_W'(32);
    endcase
  end

  assign stride = is_pcm ? wl : CNT_W'(cfg_slot_len);
  assign base   = CNT_W'(cfg_offset)
                + CNT_W'(is_i2s | (is_pcm & cfg_pcm_dly))
                + (is_rj ? CNT_W'(cfg_slot_len) - wl : '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fs_q  <= 1'b0;
      cnt_q <= PMAX;
    end else begin
      fs_q  <= fs;
      cnt_q <= pos;
    end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CNT_W-1:0] st, diff;
    logic [IW-1:0]    idx;
    logic [WMAX-1:0]  hold_q, sr_q, word, nxt;
    logic             act;

    assign act  = cfg_tdm || (c < 2);
    assign st   = base + CNT_W'(c) * stride;
    assign diff = pos - st;
    assign idx  = IW'(wl - CNT_W'(1) - diff);
    assign word = start ? tx_data[c*WMAX +: WMAX] : hold_q;

    assign win_v[c]  = act && (pos >= st) && (pos < st + wl);
    assign tx_bit[c] = win_v[c] & word[idx];
    assign last_v[c] = win_v[c] && (pos == st + wl - CNT_W'(1));

    always_comb begin
      if (!win_v[c])      nxt = sr_q;
      else if (pos == st) nxt = WMAX'(sdi);
      else                nxt = {sr_q[WMAX-2:0], sdi};
    end
    assign rx_nxt[c*WMAX +: WMAX] = nxt;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        hold_q <= '0;
        sr_q   <= '0;
      end else begin
        if (start) hold_q <= tx_data[c*WMAX +: WMAX];
        sr_q <= nxt;
      end
  end

  assign done   = cfg_tdm ? last_v[NCH-1] : last_v[1];
  assign sdo    = |tx_bit;
  assign sdo_oe = cfg_out_en & ~cfg_tri;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= done;
      if (done) rx_data <= rx_nxt;
    end

  assert_frame_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0));
  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == PMAX && !start) |-> !sdo);
  assert_one_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_v));
endmodule

// File: tb/test_tdm_serial_port.sv
module test_tdm_serial_port;
  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_fmt = 1, cfg_wlen = 0;
  logic cfg_pcm_dly = 0, cfg_tdm = 0, cfg_out_en = 1, cfg_tri = 0;
  logic [6:0] cfg_slot_len = 32;
  logic [9:0] cfg_offset = 0;
  logic fs = 0, sdi = 0;
  logic [127:0] tx_data = '0;
  logic sdo, sdo_oe, rx_valid;
  logic [127:0] rx_data;
  int vectors = 0, errors = 0;

  always #5 clk = ~clk;

  tdm_serial_port i_tdm_serial_port (
    .clk, .rst_n, .cfg_fmt, .cfg_pcm_dly, .cfg_tdm, .cfg_wlen, .cfg_slot_len,
    .cfg_offset, .cfg_out_en, .cfg_tri, .fs, .sdi, .tx_data, .sdo, .sdo_oe,
    .rx_data, .rx_valid);

  function automatic string req_of(int f);
    case (f)
      0: return "R5";
      1: return "R3";
      2: return "R4";
      default: return "R6";
    endcase
  endfunction

  // MSB position per channel, written from R3..R7
  function automatic int st_of(int f, int pd, int c, int wl, int s, int o);
    int d, stride, pad;
    d = (f == 2 || (f == 3 && pd != 0)) ? 1 : 0;
    stride = (f == 3) ? wl : s;
    pad = (f == 0) ? s - wl : 0;
    return o + d + pad + c * stride;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(int f, int pd, int tdm, int wsel, int o, int s);
    logic [31:0] txw [4];
    logic [31:0] rxw [4];
    int wl, nch, last, fslen, act_lvl;
    longint mask;
    wl = (wsel == 0) ? 16 : (wsel == 1) ? 20 : (wsel == 2) ? 24 : 32;
    mask = (64'd1 << wl) - 1;
    nch = tdm ? 4 : 2;
    act_lvl = (f == 2) ? 0 : 1;
    fslen = (f == 3) ? 1 : (tdm ? 2 * s : s);
    for (int c = 0; c < 4; c++) begin
      txw[c] = $urandom;
      rxw[c] = $urandom;
    end
    @(negedge clk);
    cfg_fmt = 2'(f); cfg_pcm_dly = 1'(pd); cfg_tdm = 1'(tdm);
    cfg_wlen = 2'(wsel); cfg_offset = 10'(o); cfg_slot_len = 7'(s);
    fs = 1'(1 - act_lvl);
    for (int c = 0; c < 4; c++) tx_data[c*32 +: 32] = txw[c];
    @(negedge clk);
    last = st_of(f, pd, nch - 1, wl, s, o) + wl - 1;
    for (int p = 0; p <= last + 2; p++) begin
      int exp_bit, in_bit;
      if (p > 0) @(negedge clk);
      fs = (p < fslen) ? 1'(act_lvl) : 1'(1 - act_lvl);
      if (p == 1) for (int c = 0; c < 4; c++) tx_data[c*32 +: 32] = ~txw[c]; // R12
      exp_bit = 0;
      in_bit = 1;  // junk outside windows, must be ignored (R9)
      for (int c = 0; c < nch; c++) begin
        int st;
        st = st_of(f, pd, c, wl, s, o);
        if (p >= st && p < st + wl) begin
          exp_bit = int'(txw[c][wl - 1 - (p - st)]);
          in_bit  = int'(rxw[c][wl - 1 - (p - st)]);
        end
      end
      sdi = 1'(in_bit);
      #3;
      // R7 R8 R9 R12 apply to every bit as well as the format requirement
      check(req_of(f), $sformatf("sdo fmt=%0d pd=%0d tdm=%0d w=%0d o=%0d s=%0d pos=%0d",
            f, pd, tdm, wl, o, s, p), longint'(sdo), longint'(exp_bit));
      @(posedge clk); #1;
      check("R10", $sformatf("rx_valid pos=%0d", p), longint'(rx_valid),
            longint'(p == last));
    end
    for (int c = 0; c < nch; c++)
      check("R9", $sformatf("rx_data ch%0d fmt=%0d w=%0d tdm=%0d", c, f, wl, tdm),
            longint'(rx_data[c*32 +: 32]), longint'(rxw[c]) & mask);
    @(negedge clk);
    fs = 1'(1 - act_lvl);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #3;
    check("R1", "rx_valid after reset", longint'(rx_valid), 0);
    check("R1", "rx_data after reset", longint'(|rx_data), 0);
    check("R1", "sdo idle", longint'(sdo), 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cfg_out_en = 1'(k[0]); cfg_tri = 1'(k[1]);
      #3;
      check("R11", $sformatf("sdo_oe en=%0d tri=%0d", k[0], k[1]),
            longint'(sdo_oe), longint'(k == 1));
    end
    cfg_out_en = 1; cfg_tri = 0;
    // R2 format codes; sweep of all variants
    for (int v = 0; v < 5; v++)
      for (int wsel = 0; wsel < 4; wsel++)
        for (int tdm = 0; tdm < 2; tdm++)
          for (int oi = 0; oi < 2; oi++)
            for (int si = 0; si < 2; si++)
              run_frame((v == 4) ? 3 : v, (v == 4) ? 1 : 0, tdm, wsel,
                        oi * 5, si ? 36 : 32);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule